// File: doc/BRIEF.md
# Single-Bit Manipulation and Test Unit

This block performs one bit-level operation per accepted cycle on a byte operand. A bit selector picks one position. The block can edit that bit in place by setting, clearing or inverting it. It can test the bit into the zero flag. It can also move the bit between the operand and the carry flag, or fold it into carry with AND, OR or XOR logic. Every carry-side operation has an inverted twin, which works on the complement of the selected bit, or of carry for the store.

A surrounding datapath presents the operand, selector, opcode and the current C and Z flags with `in_valid`. One clock later the block presents the registered result. That result is the resulting byte, a write-back enable that says whether the byte must be stored, and the updated C and Z. Fetching and storing the operand are the caller's concern.

Top module: `bitop_unit`

## Requirements
- R1: While `rst` is high at a clock edge, all registered outputs (`out_valid`, `res_byte`, `wr_en`, `c_out`, `z_out`) become 0.
- R2: The selected bit position is `bit_sel` taken modulo 8 (its low 3 bits). Higher bits of `bit_sel` have no effect on any output.
- R3: Opcode 0 sets, 1 clears and 2 inverts the selected bit of `opnd`. The result goes on `res_byte` with `wr_en`=1, and C and Z are passed through unchanged.
- R4: Opcode 3 (test) sets `z_out` to 1 when the selected bit is 0 and to 0 otherwise. `res_byte` equals `opnd`, `wr_en`=0, and C is unchanged.
- R5: Opcode 4 copies the selected bit into C, and opcode 5 copies its complement. Both keep the byte, have `wr_en`=0 and leave Z unchanged.
- R6: Opcode 6 writes `c_in` into the selected bit, and opcode 7 writes its complement. All other bits are kept, `wr_en`=1, and C and Z are unchanged.
- R7: Opcodes 8, 10 and 12 set C to C AND, C OR and C XOR the selected bit. Opcodes 9, 11 and 13 do the same with the complement of the selected bit. All keep the byte, have `wr_en`=0 and leave Z unchanged.
- R8: Opcodes 14 and 15 are no-operations. `res_byte` equals `opnd`, `wr_en`=0, and C and Z are passed through.
- R9: Results appear one clock after the accepting edge, with `out_valid` high. In a cycle with `in_valid` low, `out_valid` and `wr_en` drop to 0 and `res_byte`, `c_out` and `z_out` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| opnd | input | 8 | Operand byte |
| bit_sel | input | 4 | Bit selector; only the low 3 bits are used |
| op | input | 4 | Operation code (see R3 to R8) |
| c_in | input | 1 | Current carry flag |
| z_in | input | 1 | Current zero flag |
| out_valid | output | 1 | Registered result valid |
| res_byte | output | 8 | Resulting byte |
| wr_en | output | 1 | Byte must be written back |
| c_out | output | 1 | New carry flag |
| z_out | output | 1 | New zero flag |

## Verification
The bench drives selectors 8 to 15. A design that used the top selector bit would then either edit nothing or use the wrong position. It covers each inverted twin with both carry values, which exposes a swapped inverted operand or an inverted store that writes C itself. Tests run with Z preset both ways, which catches a design that clears Z on carry operations or lets it drift on bit edits. Idle cycles with changed inputs would reveal outputs that load without a request, and opcodes 14 and 15 would reveal a stray write-back.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [3:0] {
    OP_SET  = 4'd0,  OP_CLR  = 4'd1,  OP_INV  = 4'd2,  OP_TST  = 4'd3,
    OP_LD   = 4'd4,  OP_ILD  = 4'd5,  OP_ST   = 4'd6,  OP_IST  = 4'd7,
    OP_AND  = 4'd8,  OP_IAND = 4'd9,  OP_OR   = 4'd10, OP_IOR  = 4'd11,
    OP_XOR  = 4'd12, OP_IXOR = 4'd13, OP_NOP0 = 4'd14, OP_NOP1 = 4'd15
  } bitop_e;

  function automatic logic op_writes(input bitop_e o);
    return (o == OP_SET) || (o == OP_CLR) || (o == OP_INV) ||
           (o == OP_ST)  || (o == OP_IST);
  endfunction
endpackage

// File: rtl/bit_mask_dec.sv
module bit_mask_dec #(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4
) (
  input  logic [SEL_W-1:0]  sel,
  output logic [DATA_W-1:0] mask
);
  localparam int IDX_W = $clog2(DATA_W);
  logic [IDX_W-1:0] idx;
  assign idx = sel[IDX_W-1:0];

  for (genvar i = 0; i < DATA_W; i++) begin : g_dec
    assign mask[i] = (idx == IDX_W'(i));
  end
endmodule

// File: rtl/bit_edit_unit.sv
module bit_edit_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bitop_e            op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] mask,
  input  logic              c_in,
  output logic [DATA_W-1:0] result
);
  always_comb begin
    unique case (op)
      OP_SET:  result = opnd | mask;
      OP_CLR:  result = opnd & ~mask;
      OP_INV:  result = opnd ^ mask;
      OP_ST:   result = (opnd & ~mask) | (c_in ? mask : '0);
      OP_IST:  result = (opnd & ~mask) | (c_in ? '0 : mask);
      default: result = opnd;
    endcase
  end
endmodule

// File: rtl/flag_logic_unit.sv
module flag_logic_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  bitop_e            op,
  input  logic [DATA_W-1:0] opnd,
  input  logic [DATA_W-1:0] mask,
  input  logic              c_in,
  input  logic              z_in,
  output logic              c_new,
  output logic              z_new
);
  logic sbit;
  logic obit;
  assign sbit = |(opnd & mask);
  // odd carry-side opcodes use the complemented bit
  assign obit = op[0] ? ~sbit : sbit;

  always_comb begin
    c_new = c_in;
    z_new = z_in;
    unique case (op)
      OP_TST:                 z_new = ~sbit;
      OP_LD,  OP_ILD:         c_new = obit;
      OP_AND, OP_IAND:        c_new = c_in & obit;
      OP_OR,  OP_IOR:         c_new = c_in | obit;
      OP_XOR, OP_IXOR:        c_new = c_in ^ obit;
      default: ;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SEL_W  = 4,
  parameter int OP_W   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] opnd,
  input  logic [SEL_W-1:0]  bit_sel,
  input  logic [OP_W-1:0]   op,
  input  logic              c_in,
  input  logic              z_in,
  output logic              out_valid,
  output logic [DATA_W-1:0] res_byte,
  output logic              wr_en,
  output logic              c_out,
  output logic              z_out
);
  bitop_e            op_e;
  logic [DATA_W-1:0] mask;
  logic [DATA_W-1:0] edit_res;
  logic              c_nxt, z_nxt;

  assign op_e = bitop_e'(op);

  bit_mask_dec #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_dec (
    .sel(bit_sel), .mask(mask));

  bit_edit_unit #(.DATA_W(DATA_W)) u_edit (
    .op(op_e), .opnd(opnd), .mask(mask), .c_in(c_in), .result(edit_res));

  flag_logic_unit #(.DATA_W(DATA_W)) u_flag (
    .op(op_e), .opnd(opnd), .mask(mask), .c_in(c_in), .z_in(z_in),
    .c_new(c_nxt), .z_new(z_nxt));

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      res_byte  <= '0;
      c_out     <= 1'b0;
      z_out     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && op_writes(op_e);
      if (in_valid) begin
        res_byte <= edit_res;
        c_out    <= c_nxt;
        z_out    <= z_nxt;
      end
    end
  end

  // R3
  set_wb_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd0) |=> (wr_en && out_valid && ((res_byte & $past(mask)) == $past(mask))));
  // R4
  test_keeps_c_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd3) |=> (!wr_en && c_out == $past(c_in) && res_byte == $past(opnd)));
  // R8
  nop_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op >= 4'd14) |=> (!wr_en && res_byte == $past(opnd) &&
                                   c_out == $past(c_in) && z_out == $past(z_in)));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en && $stable(res_byte) && $stable(c_out) && $stable(z_out)));
  // R2
  one_hot_mask_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(mask) && $countones(mask) == 1);
  // R6
  store_bit_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && op == 4'd6) |=> (wr_en && ((res_byte & $past(mask)) != '0) == $past(c_in)));
endmodule

// File: tb/bitop_unit_tb_top.sv
module bitop_unit_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [7:0] opnd = '0;
  logic [3:0] bit_sel = '0;
  logic [3:0] op = '0;
  logic       c_in = 1'b0;
  logic       z_in = 1'b0;
  logic       out_valid, wr_en, c_out, z_out;
  logic [7:0] res_byte;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #10 clk = ~clk;  // 50 MHz

  bitop_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .opnd(opnd), .bit_sel(bit_sel),
    .op(op), .c_in(c_in), .z_in(z_in), .out_valid(out_valid),
    .res_byte(res_byte), .wr_en(wr_en), .c_out(c_out), .z_out(z_out));

  // packed {valid, res, wr, c, z}
  function automatic logic [11:0] model(input logic [7:0] d, input logic [3:0] s,
                                        input logic [3:0] o, input logic c, input logic z);
    logic [7:0] r;
    logic b, nb, nc, nz, w;
    int p;
    p = int'(s[2:0]);
    b = d[p];
    r = d; nc = c; nz = z; w = 1'b0;
    case (o)
      4'd0: begin r[p] = 1'b1; w = 1'b1; end
      4'd1: begin r[p] = 1'b0; w = 1'b1; end
      4'd2: begin r[p] = ~b;   w = 1'b1; end
      4'd3: nz = ~b;
      4'd4: nc = b;
      4'd5: nc = ~b;
      4'd6: begin r[p] = c;  w = 1'b1; end
      4'd7: begin r[p] = ~c; w = 1'b1; end
      default: begin
        if (o >= 4'd8 && o <= 4'd13) begin
          nb = o[0] ? ~b : b;
          if (o <= 4'd9) nc = c & nb;
          else if (o <= 4'd11) nc = c | nb;
          else nc = c ^ nb;
        end
      end
    endcase
    return {1'b1, r, w, nc, nz};
  endfunction

  function automatic string req_of(input logic [3:0] o);
    if (o <= 4'd2) return "R3";
    if (o == 4'd3) return "R4";
    if (o <= 4'd5) return "R5";
    if (o <= 4'd7) return "R6";
    if (o <= 4'd13) return "R7";
    return "R8";
  endfunction

  task automatic check(input string req, input logic [11:0] got, input logic [11:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // drive at negedge, result visible after next posedge, sample at following negedge
  task automatic run_op(input logic [7:0] d, input logic [3:0] s, input logic [3:0] o,
                        input logic c, input logic z, input string req);
    in_valid = 1'b1; opnd = d; bit_sel = s; op = o; c_in = c; z_in = z;
    @(negedge clk);
    in_valid = 1'b0;
    check(req, {out_valid, res_byte, wr_en, c_out, z_out}, model(d, s, o, c, z));
  endtask

  initial begin
    #3000000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] held;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {out_valid, res_byte, wr_en, c_out, z_out}, 12'h000);
    rst = 1'b0;
    @(negedge clk);

    // directed: every opcode, both carry values, Z preset both ways
    for (int o = 0; o < 16; o++)
      for (int c = 0; c < 2; c++)
        run_op(8'hA5, 4'(o % 8), 4'(o), c[0], c[0], req_of(4'(o)));

    // R2 selector wrap: 8..15 must act like 0..7
    for (int s = 8; s < 16; s++) begin
      run_op(8'h00, 4'(s), 4'd0, 1'b0, 1'b0, "R2");
      run_op(8'hFF, 4'(s), 4'd3, 1'b1, 1'b0, "R2");
    end
    // R4 test of a zero bit and a one bit with Z preset opposite
    run_op(8'hFE, 4'd0, 4'd3, 1'b1, 1'b0, "R4");
    run_op(8'h01, 4'd0, 4'd3, 1'b0, 1'b1, "R4");
    // R6 inverted store on every position
    for (int s = 0; s < 8; s++) run_op(8'h5A, 4'(s), 4'd7, s[0], 1'b1, "R6");

    // R9 idle cycles: inputs change, outputs hold
    run_op(8'h3C, 4'd2, 4'd2, 1'b1, 1'b0, "R9");
    held = {1'b0, res_byte, 1'b0, c_out, z_out};
    opnd = 8'hFF; op = 4'd1; c_in = 1'b0; z_in = 1'b1; bit_sel = 4'd5;
    @(negedge clk);
    check("R9", {out_valid, res_byte, wr_en, c_out, z_out}, held);
    @(negedge clk);
    check("R9", {out_valid, res_byte, wr_en, c_out, z_out}, held);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [3:0] ro;
      ro = 4'($urandom_range(0, 15));
      run_op(8'($urandom), 4'($urandom), ro, 1'($urandom), 1'($urandom), req_of(ro));
    end

    // back-to-back accepts
    in_valid = 1'b1; opnd = 8'h0F; bit_sel = 4'd7; op = 4'd0; c_in = 1'b0; z_in = 1'b0;
    @(negedge clk);
    check("R9", {out_valid, res_byte, wr_en, c_out, z_out}, model(8'h0F, 4'd7, 4'd0, 1'b0, 1'b0));
    opnd = 8'hF0; bit_sel = 4'd4; op = 4'd6; c_in = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", {out_valid, res_byte, wr_en, c_out, z_out}, model(8'hF0, 4'd4, 4'd6, 1'b0, 1'b0));

    // R1 reset again mid-run
    rst = 1'b1;
    @(negedge clk);
    check("R1", {out_valid, res_byte, wr_en, c_out, z_out}, 12'h000);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule